// File: doc/BRIEF.md
# I2C Receive Acknowledge and Clock-Stretch Controller

This block manages the byte-level flow of an I2C receiver. It watches the synchronised SCL and SDA levels, counts clock pulses inside each byte and shifts received data into a shift register. Completed bytes move into a holding register that software reads through a strobe. A data-ready flag rises either on the eighth or on the ninth SCL rising edge, depending on a control bit.

The controller can request that SCL be held low. It does this after the eighth bit, so software can inspect the data and then pick ACK or NACK. It does this after the ninth bit when byte-at-a-time reception is chosen. It also does this when a new byte completes while the holding register is still full. While receiving, it presents the acknowledge level for the ACK slot from a write-protected register bit. While transmitting, it records the acknowledge bit returned by the far end.

A single control word is written through `reg_wr_i`/`reg_wdata_i`, and its state is always visible on `reg_rdata_o`. Start and stop detection, the transmit/receive direction and the "this controller asked for the stop" indication come from the surrounding I2C engine.

Top module: `i2c_rxack_ctrl`

## Requirements
- R1: The byte bit counter restarts at bit 0 whenever `start_det_i` or `stop_det_i` is high, so a partial byte before a repeated start is discarded and the next 8 bits form a clean byte.
- R2: In receive mode (`tx_mode_i`=0), data bits are sampled on the SCL rising edges, MSB first, and the completed byte appears on `rx_data_o`.
- R3: With early select (write bit 2) at 0, `data_ready_o` rises one clock after the ninth SCL rising edge. It stays 0 after the eighth rising edge, and SCL is not held after the eighth falling edge.
- R4: With early select at 1, `data_ready_o` rises one clock after the eighth SCL rising edge, and `scl_hold_o` goes high after the eighth falling edge. The hold stays until a register write with bit 1 (unlock) set.
- R5: With wait (write bit 3) at 1, `scl_hold_o` goes high after the ninth falling edge if the byte is still unread. A pulse on `rd_strobe_i` releases it.
- R6: If a byte completes while `data_ready_o` is already 1 and no read occurs in that cycle, SCL is held from the ninth falling edge. A read then returns the older byte, moves the new byte into the holding register, keeps `data_ready_o` at 1 and releases the hold.
- R7: A read strobe clears `data_ready_o`. A read in the same cycle as a byte completion counts as freeing the holding register: the new byte is loaded, `data_ready_o` stays 1 and no hold follows.
- R8: In receive mode, `sda_o` carries the transmit-acknowledge bit (0 = ACK, 1 = NACK) from the eighth SCL falling edge to the ninth falling edge. At all other times and in transmit mode it is 1 (released).
- R9: The transmit-acknowledge bit (read bit 0) takes write bit 0 only when write bit 1 (unlock) is also 1. A write with unlock at 0 leaves it unchanged.
- R10: A stop detection while `stop_req_i` is 1 clears the transmit-acknowledge bit. A stop detection without `stop_req_i` leaves it unchanged.
- R11: In transmit mode, the SDA level at the ninth SCL rising edge is stored as the received-acknowledge bit (read bit 6, 1 = NACK). `data_ready_o` does not rise.
- R12: A write with bit 5 (soft reset) clears both acknowledge bits only while the stored enable bit (bit 4) is 0. While enable is 1, the soft reset has no effect.
- R13: After `rst_ni` is released, `scl_hold_o`, `data_ready_o` and `reg_rdata_o` are 0 and `sda_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| start_det_i | input | 1 | Start or repeated start detected |
| stop_det_i | input | 1 | Stop condition detected |
| stop_req_i | input | 1 | This controller requested the stop now on the bus |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| rd_strobe_i | input | 1 | One-cycle read of the receive data register |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | REG_W | Control word write data |
| reg_rdata_o | output | REG_W | Control and status readback |
| rx_data_o | output | BYTE_BITS | Holding register contents |
| data_ready_o | output | 1 | Receive data ready flag |
| scl_hold_o | output | 1 | Request to hold SCL low |
| sda_o | output | 1 | SDA level to drive (1 = released) |

## Verification
Two functions can collide in one clock: completing a byte into the holding register, and software draining that register with `rd_strobe_i`. The bench leaves one byte unread. It then clocks a second byte and raises the read strobe in exactly the cycle of the ninth SCL rising edge. It judges the result in three ways: the old byte must be read out, `data_ready_o` must stay 1 with the new byte present, and no clock hold may follow the ninth falling edge. A second collision is also provoked: an acknowledge write that releases the eighth-bit hold. After it, SCL must be released and the written value must appear on `sda_o` in the same cycle.

// File: rtl/i2c_rxack_pkg.sv
package i2c_rxack_pkg;
  // control word write fields
  localparam int unsigned F_ACK    = 0;
  localparam int unsigned F_UNLOCK = 1;
  localparam int unsigned F_EARLY  = 2;
  localparam int unsigned F_WAIT   = 3;
  localparam int unsigned F_EN     = 4;
  localparam int unsigned F_SRST   = 5;
  localparam int unsigned F_RXACK  = 6;  // readback only

  typedef struct packed {
    logic data_rise;  // rising edge of a data bit
    logic last_rise;  // rising edge of the final data bit
    logic ack_rise;   // rising edge of the ack bit
    logic last_fall;  // falling edge after the final data bit
    logic ack_fall;   // falling edge after the ack bit
  } scl_evt_t;
endpackage

// File: rtl/i2c_rxack_bitcnt.sv
module i2c_rxack_bitcnt
  import i2c_rxack_pkg::*;
#(
  parameter int unsigned BYTE_BITS = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     start_i,
  input  logic     stop_i,
  output scl_evt_t evt_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(BYTE_BITS + 1);

  logic             scl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise, fall, clr;

  assign clr  = start_i | stop_i;
  assign rise = scl_i & ~scl_q & ~clr;
  assign fall = ~scl_i & scl_q & ~clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      scl_q <= scl_i;
      if (clr)                               cnt_q <= '0;
      else if (rise && cnt_q <= CNT_ACK)     cnt_q <= cnt_q + 1'b1;
      else if (fall && cnt_q == CNT_DONE)    cnt_q <= '0;
    end
  end

  always_comb begin
    evt_o.data_rise = rise && (cnt_q < CNT_ACK);
    evt_o.last_rise = rise && (cnt_q == CNT_LAST);
    evt_o.ack_rise  = rise && (cnt_q == CNT_ACK);
    evt_o.last_fall = fall && (cnt_q == CNT_ACK);
    evt_o.ack_fall  = fall && (cnt_q == CNT_DONE);
  end
endmodule

// File: rtl/i2c_rxack_buffer.sv
module i2c_rxack_buffer #(
  parameter int unsigned BYTE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_en_i,
  input  logic                 early_i,
  input  logic                 sda_i,
  input  logic                 data_rise_i,
  input  logic                 last_rise_i,
  input  logic                 ack_rise_i,
  input  logic                 rd_i,
  output logic [BYTE_BITS-1:0] data_o,
  output logic                 ready_o,
  output logic                 pending_o,
  output logic                 load_o
);
  logic [BYTE_BITS-1:0] shift_q, shift_nxt, hold_q, load_data;
  logic                 ready_q, pend_q, load_src, overrun;

  assign shift_nxt = {shift_q[BYTE_BITS-2:0], sda_i};
  // early select completes the byte with the final data bit still in flight
  assign load_src  = rx_en_i && (early_i ? last_rise_i : ack_rise_i);
  assign load_data = early_i ? shift_nxt : shift_q;
  assign load_o    = load_src && (!ready_q || rd_i);
  assign overrun   = load_src && ready_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      hold_q  <= '0;
      ready_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (rx_en_i && data_rise_i) shift_q <= shift_nxt;
      if (load_o) begin
        hold_q  <= load_data;
        ready_q <= 1'b1;
      end else if (overrun) begin
        pend_q  <= 1'b1;
      end else if (rd_i && pend_q) begin
        hold_q  <= shift_q;
        pend_q  <= 1'b0;
      end else if (rd_i) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign data_o    = hold_q;
  assign ready_o   = ready_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/i2c_rxack_stretch.sv
module i2c_rxack_stretch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic early_i,
  input  logic wait_i,
  input  logic ready_i,
  input  logic pending_i,
  input  logic rd_i,
  input  logic ack_wr_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic last_fall_i,
  input  logic ack_fall_i,
  output logic hold8_o,
  output logic hold_o,
  output logic ack_slot_o
);
  logic hold8_q, hold9_q, slot_q, bus_clr, hold9_set;

  assign bus_clr   = start_i | stop_i;
  assign hold9_set = ack_fall_i && rx_en_i && !rd_i &&
                     (pending_i || (wait_i && ready_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold8_q <= 1'b0;
      hold9_q <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      // an ack write in the same cycle as the eighth fall pre-empts the hold
      if (bus_clr || ack_wr_i)                      hold8_q <= 1'b0;
      else if (last_fall_i && rx_en_i && early_i)   hold8_q <= 1'b1;

      if (bus_clr || rd_i)                          hold9_q <= 1'b0;
      else if (hold9_set)                           hold9_q <= 1'b1;

      if (bus_clr || ack_fall_i)                    slot_q  <= 1'b0;
      else if (last_fall_i && rx_en_i)              slot_q  <= 1'b1;
    end
  end

  assign hold8_o    = hold8_q;
  assign hold_o     = hold8_q | hold9_q;
  assign ack_slot_o = slot_q;
endmodule

// File: rtl/i2c_rxack_ackreg.sv
module i2c_rxack_ackreg
  import i2c_rxack_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             stop_i,
  input  logic             stop_req_i,
  input  logic             tx_mode_i,
  input  logic             ack_rise_i,
  input  logic             sda_i,
  output logic             ack_bit_o,
  output logic             rx_ack_o,
  output logic             early_o,
  output logic             wait_o,
  output logic             ack_wr_o,
  output logic             srst_o,
  output logic [REG_W-1:0] rdata_o
);
  logic ack_q, rx_ack_q, early_q, wait_q, en_q;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:F_SRST+1];
  assign srst_o   = reg_wr_i && reg_wdata_i[F_SRST] && !en_q;
  assign ack_wr_o = reg_wr_i && reg_wdata_i[F_UNLOCK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      rx_ack_q <= 1'b0;
      early_q  <= 1'b0;
      wait_q   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        early_q <= reg_wdata_i[F_EARLY];
        wait_q  <= reg_wdata_i[F_WAIT];
        en_q    <= reg_wdata_i[F_EN];
      end
      if (srst_o)                   ack_q <= 1'b0;
      else if (ack_wr_o)            ack_q <= reg_wdata_i[F_ACK];
      else if (stop_i && stop_req_i) ack_q <= 1'b0;

      if (srst_o)                       rx_ack_q <= 1'b0;
      else if (tx_mode_i && ack_rise_i) rx_ack_q <= sda_i;
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[F_ACK]   = ack_q;
    rdata_o[F_EARLY] = early_q;
    rdata_o[F_WAIT]  = wait_q;
    rdata_o[F_EN]    = en_q;
    rdata_o[F_RXACK] = rx_ack_q;
  end

  assign ack_bit_o = ack_q;
  assign rx_ack_o  = rx_ack_q;
  assign early_o   = early_q;
  assign wait_o    = wait_q;
endmodule

// File: rtl/i2c_rxack_ctrl.sv
module i2c_rxack_ctrl
  import i2c_rxack_pkg::*;
#(
  parameter int unsigned BYTE_BITS = 8,
  parameter int unsigned REG_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 start_det_i,
  input  logic                 stop_det_i,
  input  logic                 stop_req_i,
  input  logic                 tx_mode_i,
  input  logic                 rd_strobe_i,
  input  logic                 reg_wr_i,
  input  logic [REG_W-1:0]     reg_wdata_i,
  output logic [REG_W-1:0]     reg_rdata_o,
  output logic [BYTE_BITS-1:0] rx_data_o,
  output logic                 data_ready_o,
  output logic                 scl_hold_o,
  output logic                 sda_o
);
  scl_evt_t evt;
  logic rx_en, early_w, wait_w, ack_bit_w, rx_ack_w, ack_wr_w, srst_w;
  logic pending_w, load_w, hold8_w, slot_w;

  assign rx_en = ~tx_mode_i;

  i2c_rxack_bitcnt #(.BYTE_BITS(BYTE_BITS)) u_bitcnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .start_i (start_det_i),
    .stop_i  (stop_det_i),
    .evt_o   (evt)
  );

  i2c_rxack_buffer #(.BYTE_BITS(BYTE_BITS)) u_buffer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_en_i     (rx_en),
    .early_i     (early_w),
    .sda_i       (sda_i),
    .data_rise_i (evt.data_rise),
    .last_rise_i (evt.last_rise),
    .ack_rise_i  (evt.ack_rise),
    .rd_i        (rd_strobe_i),
    .data_o      (rx_data_o),
    .ready_o     (data_ready_o),
    .pending_o   (pending_w),
    .load_o      (load_w)
  );

  i2c_rxack_stretch u_stretch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_en_i     (rx_en),
    .early_i     (early_w),
    .wait_i      (wait_w),
    .ready_i     (data_ready_o),
    .pending_i   (pending_w),
    .rd_i        (rd_strobe_i),
    .ack_wr_i    (ack_wr_w),
    .start_i     (start_det_i),
    .stop_i      (stop_det_i),
    .last_fall_i (evt.last_fall),
    .ack_fall_i  (evt.ack_fall),
    .hold8_o     (hold8_w),
    .hold_o      (scl_hold_o),
    .ack_slot_o  (slot_w)
  );

  i2c_rxack_ackreg #(.REG_W(REG_W)) u_ackreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .stop_i      (stop_det_i),
    .stop_req_i  (stop_req_i),
    .tx_mode_i   (tx_mode_i),
    .ack_rise_i  (evt.ack_rise),
    .sda_i       (sda_i),
    .ack_bit_o   (ack_bit_w),
    .rx_ack_o    (rx_ack_w),
    .early_o     (early_w),
    .wait_o      (wait_w),
    .ack_wr_o    (ack_wr_w),
    .srst_o      (srst_w),
    .rdata_o     (reg_rdata_o)
  );

  assign sda_o = slot_w ? ack_bit_w : 1'b1;
endmodule

// File: rtl/i2c_rxack_ctrl_chk.sv
module i2c_rxack_ctrl_chk
  import i2c_rxack_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_mode_i,
  input logic             rd_strobe_i,
  input logic             reg_wr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             stop_det_i,
  input logic             stop_req_i,
  input logic             data_ready_o,
  input logic             load_w,
  input logic             pending_w,
  input logic             hold8_w,
  input logic             early_w,
  input logic             srst_w,
  input logic             ack_bit_w,
  input logic             rx_ack_w
);
  AST_READY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i && !load_w && !pending_w |=> !data_ready_o); // R7

  AST_LOAD_SETS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> data_ready_o); // R3

  AST_EARLY_HOLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold8_w) |-> $past(early_w)); // R4

  AST_ACK_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_wdata_i[F_UNLOCK]) && !srst_w && !(stop_det_i && stop_req_i)
    |=> $stable(ack_bit_w)); // R9

  AST_STOP_CLEARS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i && stop_req_i && !reg_wr_i |=> !ack_bit_w); // R10

  AST_TX_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_i && !data_ready_o |=> !data_ready_o); // R11

  AST_RXACK_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_ack_w) |-> $past(tx_mode_i) || $past(srst_w)); // R11

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_w |=> !ack_bit_w && !rx_ack_w); // R12
endmodule

bind i2c_rxack_ctrl i2c_rxack_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_mode_i    (tx_mode_i),
  .rd_strobe_i  (rd_strobe_i),
  .reg_wr_i     (reg_wr_i),
  .reg_wdata_i  (reg_wdata_i),
  .stop_det_i   (stop_det_i),
  .stop_req_i   (stop_req_i),
  .data_ready_o (data_ready_o),
  .load_w       (load_w),
  .pending_w    (pending_w),
  .hold8_w      (hold8_w),
  .early_w      (early_w),
  .srst_w       (srst_w),
  .ack_bit_w    (ack_bit_w),
  .rx_ack_w     (rx_ack_w)
);

// File: tb/i2c_rxack_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_rxack_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1, sda_i = 1'b1;
  logic       start_det_i = 1'b0, stop_det_i = 1'b0, stop_req_i = 1'b0;
  logic       tx_mode_i = 1'b0, rd_strobe_i = 1'b0, reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o, rx_data_o;
  logic       data_ready_o, scl_hold_o, sda_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic       slot_sda;

  always #4 clk = ~clk;

  i2c_rxack_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .start_det_i(start_det_i), .stop_det_i(stop_det_i), .stop_req_i(stop_req_i),
    .tx_mode_i(tx_mode_i), .rd_strobe_i(rd_strobe_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .rx_data_o(rx_data_o),
    .data_ready_o(data_ready_o), .scl_hold_o(scl_hold_o), .sda_o(sda_o)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ack, unl, early, wt, en, srst);
    reg_wdata_i = {2'b00, srst, en, wt, early, unl, ack};
    reg_wr_i = 1'b1; tick(); reg_wr_i = 1'b0;
  endtask

  task automatic scl_hi(input logic b); sda_i = b; scl_i = 1'b1; tick(); endtask
  task automatic scl_lo(); scl_i = 1'b0; tick(); endtask

  task automatic start_cond();
    scl_i = 1'b1; tick(); start_det_i = 1'b1; tick(); start_det_i = 1'b0; scl_lo();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin scl_hi(b[i]); scl_lo(); end
  endtask

  // full byte; in receive mode the ack slot is driven from sda_o
  task automatic send_byte(input logic [7:0] b, input logic tx_ack, output logic slot);
    send_bits(b, 8);
    slot = sda_o;
    scl_hi(tx_mode_i ? tx_ack : sda_o);
    scl_lo();
  endtask

  // driver side pushes, this side pops and compares at the read
  task automatic read_byte(input string req);
    logic [7:0] e;
    e = exp_q.pop_front();
    chk(req, rx_data_o, e);
    rd_strobe_i = 1'b1; tick(); rd_strobe_i = 1'b0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1; tick();
    // R13 reset state
    chk("R13 hold", scl_hold_o, 0);
    chk("R13 ready", data_ready_o, 0);
    chk("R13 sda", sda_o, 1);
    chk("R13 rdata", reg_rdata_o, 0);

    wr(0, 0, 0, 0, 1, 0);
    start_cond();

    // R2 R3 R8: plain reception with ACK
    exp_q.push_back(8'hA5);
    send_bits(8'hA5, 7);
    scl_hi(1'b1);
    chk("R3 no early ready", data_ready_o, 0);
    scl_lo();
    chk("R3 no hold after 8th", scl_hold_o, 0);
    chk("R8 ack slot drives 0", sda_o, 0);
    scl_hi(sda_o);
    chk("R3 ready at 9th rise", data_ready_o, 1);
    scl_lo();
    chk("R8 released after slot", sda_o, 1);
    chk("R3 no hold after 9th", scl_hold_o, 0);
    read_byte("R2 data");
    chk("R7 read clears ready", data_ready_o, 0);

    // R1: repeated start discards a partial byte
    send_bits(8'hFF, 3);
    start_cond();
    exp_q.push_back(8'h5A);
    send_byte(8'h5A, 1'b0, slot_sda);
    read_byte("R1 clean byte after restart");

    // R6: overrun stretch
    exp_q.push_back(8'h3C);
    exp_q.push_back(8'hC3);
    send_byte(8'h3C, 1'b0, slot_sda);
    send_byte(8'hC3, 1'b0, slot_sda);
    chk("R6 hold on overrun", scl_hold_o, 1);
    repeat (3) tick();
    chk("R6 hold persists", scl_hold_o, 1);
    read_byte("R6 older byte");
    chk("R6 hold released", scl_hold_o, 0);
    chk("R6 ready stays", data_ready_o, 1);
    read_byte("R6 newer byte");
    chk("R6 ready cleared", data_ready_o, 0);

    // R7: read in the same cycle as byte completion
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h22);
    send_byte(8'h11, 1'b0, slot_sda);
    send_bits(8'h22, 8);
    chk("R7 old byte at collision", rx_data_o, exp_q.pop_front());
    rd_strobe_i = 1'b1; sda_i = sda_o; scl_i = 1'b1; tick(); rd_strobe_i = 1'b0;
    chk("R7 ready after collision", data_ready_o, 1);
    scl_lo();
    chk("R7 no hold after collision", scl_hold_o, 0);
    read_byte("R7 new byte");

    // R9 write protection, R8 NACK
    wr(1, 0, 0, 0, 1, 0);
    chk("R9 locked write ignored", reg_rdata_o[0], 0);
    wr(1, 1, 0, 0, 1, 0);
    chk("R9 unlocked write", reg_rdata_o[0], 1);
    exp_q.push_back(8'h96);
    send_byte(8'h96, 1'b0, slot_sda);
    chk("R8 nack in slot", slot_sda, 1);
    read_byte("R2 data 96");

    // R10 stop clears only when requested
    stop_det_i = 1'b1; tick(); stop_det_i = 1'b0;
    chk("R10 unrequested stop", reg_rdata_o[0], 1);
    stop_req_i = 1'b1; stop_det_i = 1'b1; tick(); stop_det_i = 1'b0; stop_req_i = 1'b0;
    chk("R10 requested stop clears", reg_rdata_o[0], 0);
    start_cond();

    // R4 early flag and hold after eighth bit
    wr(0, 0, 1, 0, 1, 0);
    exp_q.push_back(8'hE7);
    send_bits(8'hE7, 7);
    scl_hi(1'b1);
    chk("R4 ready at 8th rise", data_ready_o, 1);
    scl_lo();
    chk("R4 hold after 8th fall", scl_hold_o, 1);
    repeat (3) tick();
    chk("R4 hold persists", scl_hold_o, 1);
    wr(1, 1, 1, 0, 1, 0);
    chk("R4 ack write releases", scl_hold_o, 0);
    chk("R8 written nack driven", sda_o, 1);
    scl_hi(sda_o);
    scl_lo();
    chk("R4 no hold at 9th", scl_hold_o, 0);
    read_byte("R4 early data");

    // R5 wait mode
    wr(0, 1, 0, 1, 1, 0);
    exp_q.push_back(8'h4B);
    send_byte(8'h4B, 1'b0, slot_sda);
    chk("R5 hold after 9th", scl_hold_o, 1);
    repeat (2) tick();
    chk("R5 hold persists", scl_hold_o, 1);
    read_byte("R5 data");
    chk("R5 read releases", scl_hold_o, 0);

    // R11 transmit mode ack capture
    wr(0, 1, 0, 0, 1, 0);
    tx_mode_i = 1'b1;
    send_bits(8'h81, 8);
    chk("R8 released in tx", sda_o, 1);
    scl_hi(1'b0); scl_lo();
    chk("R11 ack captured 0", reg_rdata_o[6], 0);
    send_byte(8'h7E, 1'b1, slot_sda);
    chk("R11 nack captured 1", reg_rdata_o[6], 1);
    chk("R11 no ready in tx", data_ready_o, 0);
    tx_mode_i = 1'b0;

    // R12 soft reset gated by enable
    wr(1, 1, 0, 0, 1, 0);
    wr(0, 0, 0, 0, 1, 1);
    chk("R12 ignored ack", reg_rdata_o[0], 1);
    chk("R12 ignored rxack", reg_rdata_o[6], 1);
    wr(0, 0, 0, 0, 0, 0);
    wr(0, 0, 0, 0, 0, 1);
    chk("R12 ack cleared", reg_rdata_o[0], 0);
    chk("R12 rxack cleared", reg_rdata_o[6], 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule